// File: doc/BRIEF.md
# Microcode Control Store Sequencer

This block steps a memory controller through its microprogram. It holds an 8-bit next-address register and a 256-entry control store whose entries are 40 bits wide, split into five byte lanes. On each clock edge that is not stalled, the low nibble of the next address is filled from one of three sources. The first is an external 4-bit function code. The second is all zeros. The third is the control store word at the current address. When the third source is used, the full control store word is also captured into a registered microword. The upper nibble of the address is the upper nibble of lane 0 of that registered microword.

A sticky flag records that a function code has been loaded. If an abort then arrives while preload is inactive, the flag forces the zero source. The address register stalls while a second-stage controller has been started and reports that it is not ready. For test, the microword output can be released to high impedance, and the upper address nibble can then be supplied from a pin. The two column-strobe outputs are active-low and are held high during refresh.

There is no data stream at this block's edge: every pin is a plain level-sampled control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `ucode_seq`

## Requirements
- R1: A synchronous active-high `rst` clears the low address nibble, the registered microword and the type-loaded flag. After reset, `next_addr` is 0, `uword` is 0 and both strobes are 1.
- R2: On an unstalled edge with `load_type_n` = 0, the low address nibble takes the value of `alu_fn`. The microword holds.
- R3: On an unstalled edge with `load_type_n` = 1, the low nibble loads 0 and the microword holds when the disable condition is true. The disable condition is: type-loaded flag set, `abort` = 1 and `preload_n` = 1.
- R4: On an unstalled edge with `load_type_n` = 1 and the disable condition false, the microword loads the control store word at `next_addr`. The low nibble loads bits [3:0] of that word.
- R5: The type-loaded flag is set after any edge where `load_type_n` was 0, whether or not that edge was stalled. Only reset clears it.
- R6: When `preload_n` = 1, `start2` = 1 and `stage2_rdy` = 0, the edge is stalled. The address and the microword hold. Every other combination of these three inputs lets the edge through.
- R7: `next_addr[7:4]` equals microword bits [7:4] when `out_dis` = 0, and equals `test_addr_hi` when `out_dis` = 1. The control store is read at `next_addr`.
- R8: `out_dis` = 1 releases `uword` to high impedance without changing the register behind it. A word loaded while the output was released appears on `uword` once `out_dis` returns to 0.
- R9: `cas_n` and `cas_alt_n` are both 1 while `refresh_n` = 0. Otherwise both equal the inverse of microword bit 27.
- R10: Control store locations whose upper address nibble is 4'hF are undefined. They read as all ones in every lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_type_n | input | 1 | Active-low select of the function-code source |
| alu_fn | input | 4 | External function code for the low nibble |
| preload_n | input | 1 | Active-low preload |
| abort | input | 1 | Abort request; with the flag set it disables loading |
| start2 | input | 1 | Second stage has been started |
| stage2_rdy | input | 1 | Second stage ready |
| out_dis | input | 1 | Release the microword output and take the upper address nibble from the pin |
| test_addr_hi | input | 4 | Upper address nibble used while `out_dis` = 1 |
| refresh_n | input | 1 | Active-low refresh; holds the strobes inactive |
| next_addr | output | 8 | Current control store address |
| uword | output | 40 | Registered microword, five byte lanes, high impedance when released |
| cas_n | output | 1 | Column strobe, active low |
| cas_alt_n | output | 1 | Second copy of the column strobe, active low |

## Verification
The bench targets the edges that decide priority between sources.

An abort that arrives before any function code has been loaded must not zero the nibble. A design that is not sticky, or that sets the flag only on unstalled edges, would let a ROM load through after a stalled function-code edge.

Each of the three stall inputs is toggled alone. A design that inverts one term would freeze or advance the address on the wrong cycle.

Walks through the undefined region and through test mode confirm two things: the upper nibble follows the pin, and a word captured while the output was released shows up once it is re-enabled. A design that gates the strobes on the wrong refresh polarity shows up as a strobe mismatch during refresh.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam int ADDR_W     = 8;
  localparam int NIB_W      = 4;
  localparam int HI_W       = ADDR_W - NIB_W;
  localparam int LANE_W     = 8;
  localparam int LANES      = 5;
  localparam int WORD_W     = LANES * LANE_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int STROBE_BIT = 27;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_ALU  = 2'd1,
    SRC_ZERO = 2'd2,
    SRC_ROM  = 2'd3
  } nib_src_e;

  // Constant control store contents; an upper nibble of all ones marks an undefined slot.
  function automatic logic [WORD_W-1:0] ucs_rom_word(input logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] w;
    logic [LANE_W-1:0] mul;
    logic [LANE_W-1:0] mix;
    if (a[ADDR_W-1:NIB_W] == {HI_W{1'b1}}) return {WORD_W{1'b1}};
    w = '0;
    for (int k = 0; k < LANES; k++) begin
      mul = LANE_W'(29 + 2 * k);
      mix = LANE_W'(8'h3C + 17 * k);
      w[k*LANE_W +: LANE_W] = LANE_W'(a * mul) ^ mix;
    end
    return w;
  endfunction
endpackage

// File: rtl/ucs_rom.sv
module ucs_rom
  import ucs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata
);
  localparam int N = 1 << AW;

  logic [DW-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_rom
    assign mem[g] = DW'(ucs_rom_word(ADDR_W'(g)));
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ucs_ctrl.sv
module ucs_ctrl
  import ucs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load_type_n,
  input  logic     preload_n,
  input  logic     abort,
  input  logic     start2,
  input  logic     stage2_rdy,
  output nib_src_e src,
  output logic     type_q
);
  logic clk_en;
  logic load_dis;

  // Stall only when started, not ready, and not preloading.
  assign clk_en   = !(preload_n && start2 && !stage2_rdy);
  assign load_dis = type_q && abort && preload_n;

  always_comb begin
    if (!clk_en)          src = SRC_HOLD;
    else if (!load_type_n) src = SRC_ALU;
    else if (load_dis)     src = SRC_ZERO;
    else                   src = SRC_ROM;
  end

  always_ff @(posedge clk) begin
    if (rst)               type_q <= 1'b0;
    else if (!load_type_n) type_q <= 1'b1;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    type_q |=> type_q); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    !load_type_n |=> type_q); // R5
  AST_STALL_SRC: assert property (@(posedge clk) disable iff (rst)
    (preload_n && start2 && !stage2_rdy) |-> (src == SRC_HOLD)); // R6
endmodule

// File: rtl/ucs_addr.sv
module ucs_addr
  import ucs_pkg::*;
#(
  parameter int NW = NIB_W
) (
  input  logic          clk,
  input  logic          rst,
  input  nib_src_e      src,
  input  logic [NW-1:0] alu_fn,
  input  logic [NW-1:0] rom_nib,
  output logic [NW-1:0] nib_q
);
  always_ff @(posedge clk) begin
    if (rst) nib_q <= '0;
    else begin
      unique case (src)
        SRC_ALU:  nib_q <= alu_fn;
        SRC_ZERO: nib_q <= '0;
        SRC_ROM:  nib_q <= rom_nib;
        default:  nib_q <= nib_q;
      endcase
    end
  end

  AST_ALU_LOAD: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_ALU) |=> (nib_q == $past(alu_fn))); // R2
  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_ZERO) |=> (nib_q == '0)); // R3
  AST_NIB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_HOLD) |=> $stable(nib_q)); // R6
endmodule

// File: rtl/ucs_outreg.sv
module ucs_outreg
  import ucs_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int SB = STROBE_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] rom_data,
  input  logic          refresh_n,
  output logic [DW-1:0] word_q,
  output logic          cas_n,
  output logic          cas_alt_n
);
  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (load) word_q <= rom_data;
  end

  assign cas_n     = refresh_n ? ~word_q[SB] : 1'b1;
  assign cas_alt_n = refresh_n ? ~word_q[SB] : 1'b1;

  AST_WORD_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (word_q == $past(rom_data))); // R4
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word_q)); // R4
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (rst)
    !refresh_n |-> (cas_n && cas_alt_n)); // R9
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load_type_n,
  input  logic [NIB_W-1:0]    alu_fn,
  input  logic                preload_n,
  input  logic                abort,
  input  logic                start2,
  input  logic                stage2_rdy,
  input  logic                out_dis,
  input  logic [HI_W-1:0]     test_addr_hi,
  input  logic                refresh_n,
  output logic [ADDR_W-1:0]   next_addr,
  output wire  [WORD_W-1:0]   uword,
  output logic                cas_n,
  output logic                cas_alt_n
);
  nib_src_e          src;
  logic              type_q;
  logic [NIB_W-1:0]  nib_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] rom_data;
  logic [HI_W-1:0]   hi_sel;

  ucs_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .load_type_n(load_type_n),
    .preload_n  (preload_n),
    .abort      (abort),
    .start2     (start2),
    .stage2_rdy (stage2_rdy),
    .src        (src),
    .type_q     (type_q)
  );

  ucs_rom #(.AW(ADDR_W), .DW(WORD_W)) u_rom (
    .addr (next_addr),
    .rdata(rom_data)
  );

  ucs_addr #(.NW(NIB_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .src    (src),
    .alu_fn (alu_fn),
    .rom_nib(rom_data[NIB_W-1:0]),
    .nib_q  (nib_q)
  );

  ucs_outreg #(.DW(WORD_W), .SB(STROBE_BIT)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (src == SRC_ROM),
    .rom_data (rom_data),
    .refresh_n(refresh_n),
    .word_q   (word_q),
    .cas_n    (cas_n),
    .cas_alt_n(cas_alt_n)
  );

  assign hi_sel    = out_dis ? test_addr_hi : word_q[ADDR_W-1:NIB_W];
  assign next_addr = {hi_sel, nib_q};
  assign uword     = out_dis ? {WORD_W{1'bz}} : word_q;

  AST_UNDEF_ONES: assert property (@(posedge clk) disable iff (rst)
    (next_addr[ADDR_W-1:NIB_W] == {HI_W{1'b1}}) |-> (rom_data == {WORD_W{1'b1}})); // R10
  AST_TEST_HI: assert property (@(posedge clk) disable iff (rst)
    out_dis |-> (next_addr[ADDR_W-1:NIB_W] == test_addr_hi)); // R7
endmodule

// File: tb/ucode_seq_test.sv
`timescale 1ns/1ps
module ucode_seq_test;
  import ucs_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst = 1'b1;
  logic              load_type_n = 1'b1;
  logic [NIB_W-1:0]  alu_fn = '0;
  logic              preload_n = 1'b0;
  logic              abort = 1'b0;
  logic              start2 = 1'b0;
  logic              stage2_rdy = 1'b1;
  logic              out_dis = 1'b0;
  logic [HI_W-1:0]   test_addr_hi = '0;
  logic              refresh_n = 1'b1;
  logic [ADDR_W-1:0] next_addr;
  wire  [WORD_W-1:0] uword;
  logic              cas_n, cas_alt_n;

  ucode_seq uut (
    .clk(clk), .rst(rst), .load_type_n(load_type_n), .alu_fn(alu_fn),
    .preload_n(preload_n), .abort(abort), .start2(start2),
    .stage2_rdy(stage2_rdy), .out_dis(out_dis), .test_addr_hi(test_addr_hi),
    .refresh_n(refresh_n), .next_addr(next_addr), .uword(uword),
    .cas_n(cas_n), .cas_alt_n(cas_alt_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [NIB_W-1:0]  m_nib = '0;
  logic [WORD_W-1:0] m_word = '0;
  bit                m_type = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    logic [ADDR_W-1:0] ea;
    logic              es;
    ea = {out_dis ? test_addr_hi : m_word[ADDR_W-1:NIB_W], m_nib};
    es = refresh_n ? ~m_word[STROBE_BIT] : 1'b1;
    check(req, "next_addr", 64'(next_addr), 64'(ea));
    if (!out_dis) check(req, "uword", 64'(uword), 64'(m_word));
    check(req, "cas_n", 64'(cas_n), 64'(es));
    check(req, "cas_alt_n", 64'(cas_alt_n), 64'(es));
  endtask

  // Behavioural reference: one clock edge with the inputs now applied.
  task automatic cycle(input string req);
    logic [ADDR_W-1:0] a;
    logic [WORD_W-1:0] rd, nw;
    logic [NIB_W-1:0]  nn;
    bit nt, stall, dis;
    a     = {out_dis ? test_addr_hi : m_word[ADDR_W-1:NIB_W], m_nib};
    rd    = ucs_rom_word(a);
    stall = preload_n && start2 && !stage2_rdy;
    dis   = m_type && abort && preload_n;
    nn = m_nib; nw = m_word; nt = m_type;
    if (rst) begin
      nn = '0; nw = '0; nt = 0;
    end else begin
      if (!stall) begin
        if (!load_type_n) nn = alu_fn;
        else if (dis)     nn = '0;
        else begin nn = rd[NIB_W-1:0]; nw = rd; end
      end
      if (!load_type_n) nt = 1;
    end
    @(posedge clk);
    m_nib = nn; m_word = nw; m_type = nt;
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic idle_inputs();
    load_type_n = 1; alu_fn = '0; preload_n = 0; abort = 0; start2 = 0;
    stage2_rdy = 1; out_dis = 0; test_addr_hi = '0; refresh_n = 1;
  endtask

  task automatic do_reset();
    rst = 1; cycle("R1"); cycle("R1"); rst = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle_inputs();
    do_reset();
    check("R1", "reset addr", 64'(next_addr), 64'h0);
    check("R1", "reset word", 64'(uword), 64'h0);
    check("R1", "reset strobe", 64'(cas_n), 64'h1);

    // R3 precondition: abort before any type load must not zero
    preload_n = 1; abort = 1;
    for (int i = 0; i < 3; i++) cycle("R5");
    abort = 0; preload_n = 0;

    // R2: function-code source
    load_type_n = 0;
    alu_fn = 4'h3; cycle("R2");
    alu_fn = 4'hA; cycle("R2");
    alu_fn = 4'hF; cycle("R2");
    load_type_n = 1;

    // R4: walk through the store
    for (int i = 0; i < 10; i++) cycle("R4");

    // R3 / R5: sticky flag with abort
    preload_n = 1; abort = 1;
    cycle("R3"); cycle("R3");
    check("R3", "zeroed nibble", 64'(next_addr[NIB_W-1:0]), 64'h0);
    abort = 0; cycle("R5"); cycle("R5");
    abort = 1; cycle("R5");
    preload_n = 0; cycle("R3");
    abort = 0;

    // R6: stall, each term toggled
    preload_n = 1; start2 = 1; stage2_rdy = 0; load_type_n = 0; alu_fn = 4'h5;
    cycle("R6"); cycle("R6");
    stage2_rdy = 1; cycle("R6");
    check("R6", "released nibble", 64'(next_addr[NIB_W-1:0]), 64'h5);
    stage2_rdy = 0; alu_fn = 4'h9; cycle("R6");
    start2 = 0; cycle("R6");
    start2 = 1; alu_fn = 4'h2; preload_n = 0; cycle("R6");
    start2 = 0; stage2_rdy = 1; load_type_n = 1;
    for (int i = 0; i < 4; i++) cycle("R4");

    // R5: type load on a stalled edge still sets the flag
    do_reset();
    preload_n = 1; start2 = 1; stage2_rdy = 0; load_type_n = 0; alu_fn = 4'h7;
    cycle("R5");
    load_type_n = 1; start2 = 0; stage2_rdy = 1; abort = 1;
    cycle("R5");
    check("R5", "flag set while stalled", 64'(next_addr[NIB_W-1:0]), 64'h0);
    abort = 0; preload_n = 0;

    // R9: refresh holds strobes high
    refresh_n = 0;
    for (int i = 0; i < 6; i++) cycle("R9");
    refresh_n = 1;
    for (int i = 0; i < 6; i++) cycle("R9");

    // R7 / R8: test mode
    out_dis = 1;
    test_addr_hi = 4'h2; cycle("R7");
    test_addr_hi = 4'hC; cycle("R7");
    test_addr_hi = 4'h6; cycle("R7");
    out_dis = 0; #0.1;
    check("R8", "word after release", 64'(uword), 64'(m_word));
    cycle("R8");

    // R10: undefined region
    out_dis = 1; test_addr_hi = 4'hF; cycle("R10");
    out_dis = 0; #0.1;
    check("R10", "undefined word", 64'(uword), 64'hFF_FFFF_FFFF);
    cycle("R10");
    check("R10", "undefined addr", 64'(next_addr), 64'hFF);

    // Mixed stimulus against the reference
    do_reset();
    for (int i = 0; i < 600; i++) begin
      rst          = ($urandom_range(0, 59) == 0);
      load_type_n  = ($urandom_range(0, 3) != 0);
      alu_fn       = 4'($urandom_range(0, 15));
      preload_n    = 1'($urandom_range(0, 1));
      abort        = ($urandom_range(0, 3) == 0);
      start2       = 1'($urandom_range(0, 1));
      stage2_rdy   = 1'($urandom_range(0, 1));
      out_dis      = ($urandom_range(0, 7) == 0);
      test_addr_hi = 4'($urandom_range(0, 14));
      refresh_n    = ($urandom_range(0, 4) != 0);
      cycle("R4");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule